// File: doc/BRIEF.md
# Global 64-bit Comparator Timer

A free-running 64-bit up-counter paired with one 64-bit compare register. When the counter equals the compare value, the comparator is enabled and the counter is running, a pending flag is raised. The block drives a level interrupt whenever that pending flag and its enable are both set. With auto-increment on, each match adds a programmable increment to the compare value, so the event repeats at a fixed period. With auto-increment off, the event happens once.

Software reaches the block through a plain 32-bit register bus: address, write enable, write data, read enable and read data, with reads returned in the same cycle. Writes to the counter, compare, increment and control registers reach their target a fixed number of cycles after the bus write. The moment a write takes effect, it sets a sticky per-register confirmation bit, and software clears that bit by writing 1 to it. Writes to the pending, enable and confirmation registers take effect at the bus edge itself.

Top module: `gcmp_timer`

## Requirements
- R1: After reset, every register reads zero (counter, compare, increment, control, pending, enable, confirmation flags) and `irq` is low.
- R2: While control bit 8 (run) is 1, the counter advances by one every clock. While it is 0, the counter holds its value.
- R3: The counter is 64 bits wide: its low half (0x100) wraps from 0xFFFFFFFF into an increment of its high half (0x104).
- R4: A write to 0x100, 0x104, 0x200, 0x204, 0x208 or 0x240 updates its register on the second clock edge after the bus write. On that same edge it sets its confirmation bit: 0x110 bit 0 for the counter low half and bit 1 for the high half; 0x24C bit 0 for compare low, bit 1 for compare high, bit 2 for the increment and bit 16 for control.
- R5: Writing 1 to a bit of 0x110 or 0x24C clears that bit at once. Writing 0 to it leaves it unchanged.
- R6: When control bit 0 (compare enable) is 1, run is 1 and the counter equals the compare value {0x204,0x200}, the pending flag (0x244 bit 0) is set.
- R7: Writing 1 to 0x244 bit 0 clears the pending flag. The interrupt enable is 0x248 bit 0, and `irq` is high exactly when pending and enable are both 1.
- R8: With control bit 1 (auto-increment) set, each match adds the increment value at 0x208 to the compare value.
- R9: With auto-increment clear, a match leaves the compare value unchanged, so no second match follows while the counter moves on.
- R10: Reads of unmapped addresses return zero. Writes to unmapped addresses change no register and set no confirmation bit.
- R11: With compare enable clear, the counter passing the compare value never sets the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, valid in the same cycle as rd_en, zero otherwise |
| irq | output | 1 | Level interrupt: pending AND enable |

## Verification
The hardest states to reach from the ports are the periodic re-arm sequence and the low-to-high carry. The stimulus reaches the re-arm by loading a small compare value and a random increment, letting the counter run a random number of cycles, and then stopping it. The bench then predicts the final compare value from the stopped counter value and the increment. The carry is reached by preloading the low half just below its wrap point before starting the counter.

// File: rtl/gcmp_timer.sv
module gcmp_timer #(
  parameter int ADDR_W = 12,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  output logic [31:0]       rd_data,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CNTL = ADDR_W'('h100);
  localparam logic [ADDR_W-1:0] A_CNTH = ADDR_W'('h104);
  localparam logic [ADDR_W-1:0] A_CWS  = ADDR_W'('h110);
  localparam logic [ADDR_W-1:0] A_CMPL = ADDR_W'('h200);
  localparam logic [ADDR_W-1:0] A_CMPH = ADDR_W'('h204);
  localparam logic [ADDR_W-1:0] A_INC  = ADDR_W'('h208);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'('h240);
  localparam logic [ADDR_W-1:0] A_PND  = ADDR_W'('h244);
  localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'('h248);
  localparam logic [ADDR_W-1:0] A_GWS  = ADDR_W'('h24C);

  logic [63:0] cnt, cmp, cnt_inc;
  logic [31:0] inc;
  logic        c_run, c_ai, c_en, pend, ien;
  logic [1:0]  cws;
  logic [3:0]  gws;

  logic              pv [LAT];
  logic [ADDR_W-1:0] pa [LAT];
  logic [31:0]       pd [LAT];

  wire tracked = (addr == A_CNTL) || (addr == A_CNTH) || (addr == A_CMPL) ||
                 (addr == A_CMPH) || (addr == A_INC)  || (addr == A_CTL);
  wire [ADDR_W-1:0] ap_a = pa[LAT-1];
  wire [31:0]       ap_d = pd[LAT-1];
  wire ap_cl  = pv[LAT-1] && ap_a == A_CNTL;
  wire ap_ch  = pv[LAT-1] && ap_a == A_CNTH;
  wire ap_ml  = pv[LAT-1] && ap_a == A_CMPL;
  wire ap_mh  = pv[LAT-1] && ap_a == A_CMPH;
  wire ap_inc = pv[LAT-1] && ap_a == A_INC;
  wire ap_ctl = pv[LAT-1] && ap_a == A_CTL;

  wire w_cws = wr_en && addr == A_CWS;
  wire w_gws = wr_en && addr == A_GWS;
  wire w_pnd = wr_en && addr == A_PND;
  wire w_ien = wr_en && addr == A_IEN;

  wire hit = c_en && c_run && (cnt == cmp);

  assign cnt_inc = c_run ? cnt + 64'd1 : cnt;
  assign irq     = pend & ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LAT; i++) begin
        pv[i] <= 1'b0;
        pa[i] <= '0;
        pd[i] <= '0;
      end
      cnt <= '0; cmp <= '0; inc <= '0;
      c_run <= 1'b0; c_ai <= 1'b0; c_en <= 1'b0;
      pend <= 1'b0; ien <= 1'b0; cws <= '0; gws <= '0;
    end else begin
      pv[0] <= wr_en && tracked;
      pa[0] <= addr;
      pd[0] <= wr_data;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pa[i] <= pa[i-1];
        pd[i] <= pd[i-1];
      end
      cnt[31:0]  <= ap_cl ? ap_d : cnt_inc[31:0];
      cnt[63:32] <= ap_ch ? ap_d : cnt_inc[63:32];
      if (ap_ml)            cmp[31:0]  <= ap_d;
      else if (ap_mh)       cmp[63:32] <= ap_d;
      else if (hit && c_ai) cmp        <= cmp + {32'd0, inc};
      if (ap_inc) inc <= ap_d;
      if (ap_ctl) {c_run, c_ai, c_en} <= {ap_d[8], ap_d[1], ap_d[0]};
      cws[0] <= ap_cl  | (cws[0] & ~(w_cws & wr_data[0]));
      cws[1] <= ap_ch  | (cws[1] & ~(w_cws & wr_data[1]));
      gws[0] <= ap_ml  | (gws[0] & ~(w_gws & wr_data[0]));
      gws[1] <= ap_mh  | (gws[1] & ~(w_gws & wr_data[1]));
      gws[2] <= ap_inc | (gws[2] & ~(w_gws & wr_data[2]));
      gws[3] <= ap_ctl | (gws[3] & ~(w_gws & wr_data[16]));
      pend   <= hit    | (pend & ~(w_pnd & wr_data[0]));
      if (w_ien) ien <= wr_data[0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (addr)
        A_CNTL: rd_data = cnt[31:0];
        A_CNTH: rd_data = cnt[63:32];
        A_CWS:  rd_data = {30'd0, cws};
        A_CMPL: rd_data = cmp[31:0];
        A_CMPH: rd_data = cmp[63:32];
        A_INC:  rd_data = inc;
        A_CTL:  rd_data = {23'd0, c_run, 6'd0, c_ai, c_en};
        A_PND:  rd_data = {31'd0, pend};
        A_IEN:  rd_data = {31'd0, ien};
        A_GWS:  rd_data = {15'd0, gws[3], 13'd0, gws[2:0]};
        default: rd_data = '0;
      endcase
    end
  end

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_run && !ap_cl && !ap_ch) |=> $stable(cnt));
  // R3
  carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_run && cnt[31:0] == 32'hFFFF_FFFF && !ap_cl && !ap_ch)
      |=> cnt[63:32] == $past(cnt[63:32]) + 32'd1);
  // R4
  ctl_ws_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_ctl |=> gws[3]);
  // R6
  match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_en && c_run && cnt == cmp) |=> pend);
  // R8
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && c_ai && !ap_ml && !ap_mh) |=> cmp == $past(cmp) + {32'd0, $past(inc)});
  // R9
  oneshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !c_ai && !ap_ml && !ap_mh) |=> $stable(cmp));
  // R11
  nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_en && !pend) |=> !pend);
endmodule

// File: tb/gcmp_timer_tb.sv
module gcmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  gcmp_timer u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq(irq));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic wr_ap(input logic [11:0] a, input logic [31:0] d);
    wr(a, d);
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] c0, input logic [31:0] m0,
                       input logic [31:0] iv, input logic [31:0] ctl);
    wr_ap(12'h240, 32'h0);
    wr_ap(12'h100, c0);
    wr_ap(12'h104, 32'h0);
    wr_ap(12'h200, m0);
    wr_ap(12'h204, 32'h0);
    wr_ap(12'h208, iv);
    wr(12'h244, 32'h1);
    wr_ap(12'h240, ctl);
  endtask

  function automatic logic [31:0] exp_cmp(input logic [31:0] first,
                                          input logic [31:0] iv, input logic [31:0] c);
    logic [31:0] v = first;
    while (v < c) v += iv;
    return v;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, a, b, first, iv, c;
    int unsigned seed;
    seed = $urandom(32'd2024);
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    rd(12'h100, d); chk("R1 cnt lo", d, 0);
    rd(12'h104, d); chk("R1 cnt hi", d, 0);
    rd(12'h200, d); chk("R1 cmp lo", d, 0);
    rd(12'h240, d); chk("R1 ctl", d, 0);
    rd(12'h244, d); chk("R1 pend", d, 0);
    rd(12'h24C, d); chk("R1 gws", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);

    wr(12'h100, 32'h1234);
    rd(12'h110, d); chk("R4 ws +0", d, 0);
    wait_n(1);
    rd(12'h110, d); chk("R4 ws +1", d, 0);
    rd(12'h100, d); chk("R4 cnt not yet", d, 0);
    wait_n(1);
    rd(12'h110, d); chk("R4 ws +2", d, 1);
    rd(12'h100, d); chk("R4 cnt applied", d, 32'h1234);

    wr(12'h110, 32'h0);
    rd(12'h110, d); chk("R5 write0 keeps", d, 1);
    wr(12'h110, 32'h1);
    rd(12'h110, d); chk("R5 write1 clears", d, 0);

    wr(12'h240, 32'h100);
    rd(12'h24C, d); chk("R4 ctl ws +0", d, 0);
    wait_n(1);
    rd(12'h24C, d); chk("R4 ctl ws +1", d, 0);
    wait_n(1);
    rd(12'h24C, d); chk("R4 ctl ws bit16", d, 32'h10000);
    rd(12'h100, a);
    wait_n(7);
    rd(12'h100, b); chk("R2 advance 7", b - a, 7);
    wr_ap(12'h240, 32'h0);
    rd(12'h100, a);
    wait_n(6);
    rd(12'h100, b); chk("R2 hold", b, a);

    for (int i = 0; i < 4; i++) begin
      d = $urandom;
      wr_ap(12'h104, d);
      rd(12'h104, b); chk("R4 random hi", b, d);
    end

    wr_ap(12'h100, 32'hFFFF_FFFD);
    wr_ap(12'h104, 32'h5);
    wr_ap(12'h240, 32'h100);
    wait_n(10);
    wr_ap(12'h240, 32'h0);
    rd(12'h104, d); chk("R3 carry hi", d, 6);
    rd(12'h100, d); chk("R3 low wrapped", {31'd0, d < 32'd64}, 1);

    wr(12'h110, 32'h3);
    wr(12'h24C, 32'h10007);
    rd(12'h24C, d); chk("R5 gws cleared", d, 0);
    rd(12'h0FC, d); chk("R10 read 0FC", d, 0);
    rd(12'h300, d); chk("R10 read 300", d, 0);
    rd(12'h10C, d); chk("R10 read 10C", d, 0);
    rd(12'h200, a);
    wr_ap(12'h300, 32'hFFFF_FFFF);
    wr_ap(12'h20C, 32'hFFFF_FFFF);
    wait_n(2);
    rd(12'h110, d); chk("R10 no cnt ws", d, 0);
    rd(12'h24C, d); chk("R10 no gws", d, 0);
    rd(12'h200, d); chk("R10 cmp intact", d, a);
    rd(12'h240, d); chk("R10 ctl intact", d, 0);

    wr(12'h248, 32'h1);
    setup(0, 20, 0, 32'h100);
    wait_n(40);
    rd(12'h244, d); chk("R11 no match", d, 0);
    chk("R11 irq low", {31'd0, irq}, 0);

    setup(0, 30, 0, 32'h101);
    wait_n(5);
    rd(12'h244, d); chk("R6 not yet", d, 0);
    wait_n(40);
    rd(12'h244, d); chk("R6 matched", d, 1);
    chk("R7 irq high", {31'd0, irq}, 1);
    wr(12'h248, 32'h0);
    chk("R7 irq masked", {31'd0, irq}, 0);
    rd(12'h244, d); chk("R7 pend kept", d, 1);
    wr(12'h248, 32'h1);
    chk("R7 irq unmasked", {31'd0, irq}, 1);
    wr(12'h244, 32'h1);
    rd(12'h244, d); chk("R7 pend cleared", d, 0);
    chk("R7 irq cleared", {31'd0, irq}, 0);
    rd(12'h200, d); chk("R9 cmp unchanged", d, 30);
    wait_n(40);
    rd(12'h244, d); chk("R9 no second match", d, 0);

    for (int i = 0; i < 6; i++) begin
      first = 3 + $urandom % 18;
      iv    = 5 + $urandom % 26;
      setup(0, first, iv, 32'h103);
      wait_n(50 + $urandom % 100);
      wr_ap(12'h240, 32'h0);
      rd(12'h100, c);
      rd(12'h200, d); chk("R8 rearmed cmp", d, exp_cmp(first, iv, c));
      rd(12'h244, d); chk("R8 pend", d, 1);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule